// File: doc/BRIEF.md
# Predicated Bit-Field Set Unit

This block is one slice of an execution pipeline. It takes a 32-bit data operand and forces a contiguous run of its bits to ones. The run is bounded by a low position and a high position, each five bits wide. Both positions are inclusive, and bit 0 is the least significant bit of the word. The bounds come from one of two places. In immediate form they come from two 5-bit inputs. In register form they are unpacked from the low ten bits of a second 32-bit operand.

Each issue carries a predicate. When the predicate is false, the slot turns into a no-operation: the destination write is suppressed and the data operand is passed along unchanged. In register form, a bound operand with any bit set above bit 9 is malformed. Such an issue is reported with an invalid flag and does not write the destination.

The result and its qualifiers are registered, so they appear exactly one clock after the issue. A small outcome register holds the fate of the previous issue in one of four states:
- `ST_IDLE`: nothing issued.
- `ST_WRITE`: predicate true, bounds well formed.
- `ST_SQUASH`: predicate false.
- `ST_FAULT`: predicate true, register form, malformed bounds.

On every clock the next state is chosen from the current inputs alone, so any state may move to any other:
- no `in_valid` leads to `ST_IDLE`;
- `in_valid` with `pred` low leads to `ST_SQUASH`;
- `in_valid` with `pred` high, register form and a nonzero upper part leads to `ST_FAULT`;
- any other `in_valid` leads to `ST_WRITE`.

Reset forces `ST_IDLE`.

Top module: `bfset_unit`

## Requirements
- R1: In immediate form with `pred` high, `result` equals `src_data` with every bit from `imm_lo` up to and including `imm_hi` set to 1 and all other bits copied; for example, bounds 15 and 23 on a zero operand give 0x00FF8000.
- R2: When the low bound is greater than the high bound, no bit is set and `result` equals `src_data`.
- R3: In register form the high bound is taken from `src_bounds[4:0]` and the low bound from `src_bounds[9:5]`.
- R4: In register form with `pred` high and any of `src_bounds[31:10]` nonzero, the unit raises `bad_bounds`, keeps `wr_en` low and raises `out_valid`; `result` still carries the field set from the low ten bits.
- R5: When `pred` is low, `wr_en` and `bad_bounds` stay low and `result` equals `src_data`, whatever the bounds.
- R6: `out_valid` is high exactly one clock after a cycle with `in_valid` high and low otherwise; `wr_en` is never high without `out_valid`.
- R7: A synchronous active-high `rst` clears `out_valid`, `wr_en` and `bad_bounds`.
- R8: In immediate form, `src_bounds` has no effect: a nonzero upper part raises no flag and the result depends only on the immediates.
- R9: Bounds 0 and 31 set the whole word, and equal bounds set exactly one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is issued this cycle |
| use_reg | input | 1 | 1 selects register form, 0 immediate form |
| imm_lo | input | 5 | Immediate low bound (field LSB) |
| imm_hi | input | 5 | Immediate high bound (field MSB) |
| src_bounds | input | 32 | Register operand holding packed bounds |
| src_data | input | 32 | Operand whose field is set |
| pred | input | 1 | Predicate; low turns the issue into a no-op |
| out_valid | output | 1 | Registered result slot is occupied |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Destination write enable |
| bad_bounds | output | 1 | Register-form bounds were malformed |

## Verification
The properties assume that `rst` is held high from time zero through the first clock edges. They also assume that every input is a known value and stable around each rising edge, since each property compares the registered outputs against the inputs seen one edge earlier. The bench holds `rst` high with `in_valid` low and changes inputs only on falling edges. It samples outputs shortly after the rising edge, so every sampled issue meets these assumptions.

// File: rtl/bfset_pkg.sv
package bfset_pkg;

    // Fate of the issue captured at the last clock edge.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_SQUASH = 2'd2,
        ST_FAULT  = 2'd3
    } outcome_t;

endpackage

// File: rtl/bfset_bounds.sv
// Selects the field bounds from immediates or from a packed register operand
// and flags a register operand with stray bits above the packed pair.
module bfset_bounds #(
    parameter int DATA_W = 32,
    parameter int POS_W  = 5
) (
    input  logic              use_reg,
    input  logic [POS_W-1:0]  imm_lo,
    input  logic [POS_W-1:0]  imm_hi,
    input  logic [DATA_W-1:0] src_bounds,
    output logic [POS_W-1:0]  lo_pos,
    output logic [POS_W-1:0]  hi_pos,
    output logic              upper_nz
);
    localparam int PACK_W = 2 * POS_W;

    // High bound sits in the lowest slice, low bound directly above it.
    always_comb begin
        if (use_reg) begin
            hi_pos = src_bounds[POS_W-1:0];
            lo_pos = src_bounds[PACK_W-1:POS_W];
        end else begin
            hi_pos = imm_hi;
            lo_pos = imm_lo;
        end
    end

    generate
        if (DATA_W > PACK_W) begin : g_upper
            assign upper_nz = use_reg && (|src_bounds[DATA_W-1:PACK_W]);
        end else begin : g_no_upper
            assign upper_nz = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/bfset_mask.sv
// Builds a ones-mask covering positions lo_pos..hi_pos inclusive; empty when
// lo_pos exceeds hi_pos.
module bfset_mask #(
    parameter int DATA_W = 32,
    parameter int POS_W  = 5
) (
    input  logic [POS_W-1:0]  lo_pos,
    input  logic [POS_W-1:0]  hi_pos,
    output logic [DATA_W-1:0] mask
);
    logic [DATA_W-1:0] at_or_above;
    logic [DATA_W-1:0] at_or_below;

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            localparam logic [POS_W-1:0] IDX = POS_W'(i);
            assign at_or_above[i] = (IDX >= lo_pos);
            assign at_or_below[i] = (IDX <= hi_pos);
        end
    endgenerate

    assign mask = at_or_above & at_or_below;

endmodule

// File: rtl/bfset_unit.sv
module bfset_unit #(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic                       use_reg,
    input  logic [$clog2(DATA_W)-1:0]  imm_lo,
    input  logic [$clog2(DATA_W)-1:0]  imm_hi,
    input  logic [DATA_W-1:0]          src_bounds,
    input  logic [DATA_W-1:0]          src_data,
    input  logic                       pred,
    output logic                       out_valid,
    output logic [DATA_W-1:0]          result,
    output logic                       wr_en,
    output logic                       bad_bounds
);
    import bfset_pkg::*;

    localparam int POS_W = $clog2(DATA_W);

    logic [POS_W-1:0]  lo_pos;
    logic [POS_W-1:0]  hi_pos;
    logic              upper_nz;
    logic [DATA_W-1:0] field_mask;
    logic [DATA_W-1:0] set_val;
    logic [DATA_W-1:0] res_q;
    outcome_t          state;
    outcome_t          state_nx;

    bfset_bounds #(.DATA_W(DATA_W), .POS_W(POS_W)) u_bounds (
        .use_reg    (use_reg),
        .imm_lo     (imm_lo),
        .imm_hi     (imm_hi),
        .src_bounds (src_bounds),
        .lo_pos     (lo_pos),
        .hi_pos     (hi_pos),
        .upper_nz   (upper_nz)
    );

    bfset_mask #(.DATA_W(DATA_W), .POS_W(POS_W)) u_mask (
        .lo_pos (lo_pos),
        .hi_pos (hi_pos),
        .mask   (field_mask)
    );

    assign set_val = src_data | field_mask;

    // Next outcome depends only on the current issue.
    always_comb begin
        state_nx = ST_IDLE;
        if (in_valid) begin
            if (!pred)
                state_nx = ST_SQUASH;
            else if (upper_nz)
                state_nx = ST_FAULT;
            else
                state_nx = ST_WRITE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Result datapath register; a squashed issue forwards the operand.
    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else if (in_valid)
            res_q <= pred ? set_val : src_data;
    end

    // Output decode from the outcome register.
    always_comb begin
        out_valid  = 1'b0;
        wr_en      = 1'b0;
        bad_bounds = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_WRITE:  begin out_valid = 1'b1; wr_en = 1'b1; end
            ST_SQUASH: out_valid = 1'b1;
            ST_FAULT:  begin out_valid = 1'b1; bad_bounds = 1'b1; end
        endcase
    end

    assign result = res_q;

endmodule

// File: rtl/bfset_unit_chk.sv
module bfset_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       use_reg,
    input logic [$clog2(DATA_W)-1:0]  imm_lo,
    input logic [$clog2(DATA_W)-1:0]  imm_hi,
    input logic [DATA_W-1:0]          src_bounds,
    input logic [DATA_W-1:0]          src_data,
    input logic                       pred,
    input logic                       out_valid,
    input logic [DATA_W-1:0]          result,
    input logic                       wr_en,
    input logic                       bad_bounds
);
    localparam int PACK_W = 2 * $clog2(DATA_W);

    logic upper_set;
    assign upper_set = |src_bounds[DATA_W-1:PACK_W];

    assert_only_sets_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ((result & $past(src_data)) == $past(src_data)));

    assert_empty_field_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && pred && !use_reg && (imm_lo > imm_hi)))
        |-> (result == $past(src_data)));

    assert_malformed_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && pred && use_reg && upper_set))
        |-> (bad_bounds && !wr_en && out_valid));

    assert_noop_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && !pred))
        |-> (!wr_en && !bad_bounds && result == $past(src_data)));

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    assert_wr_qualified_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> out_valid);

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !wr_en && !bad_bounds));

    assert_imm_clean_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid && pred && !use_reg))
        |-> (wr_en && !bad_bounds));

endmodule

bind bfset_unit bfset_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .use_reg    (use_reg),
    .imm_lo     (imm_lo),
    .imm_hi     (imm_hi),
    .src_bounds (src_bounds),
    .src_data   (src_data),
    .pred       (pred),
    .out_valid  (out_valid),
    .result     (result),
    .wr_en      (wr_en),
    .bad_bounds (bad_bounds)
);

// File: tb/bfset_unit_tb.sv
module bfset_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        use_reg = 1'b0;
    logic [4:0]  imm_lo = '0;
    logic [4:0]  imm_hi = '0;
    logic [31:0] src_bounds = '0;
    logic [31:0] src_data = '0;
    logic        pred = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        wr_en;
    logic        bad_bounds;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bfset_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .use_reg(use_reg),
        .imm_lo(imm_lo), .imm_hi(imm_hi), .src_bounds(src_bounds),
        .src_data(src_data), .pred(pred), .out_valid(out_valid),
        .result(result), .wr_en(wr_en), .bad_bounds(bad_bounds)
    );

    // {req[3:0], use_reg, pred, lo[4:0], hi[4:0], bounds, data, exp_result, exp_wr, exp_bad}
    localparam int NV = 11;
    localparam logic [113:0] VEC [0:NV-1] = '{
        {4'd1, 1'b0, 1'b1, 5'd15, 5'd23, 32'h0,        32'h0,        32'h00FF8000, 1'b1, 1'b0}, // R1
        {4'd1, 1'b0, 1'b1, 5'd8,  5'd15, 32'h0,        32'h000000F0, 32'h0000FFF0, 1'b1, 1'b0}, // R1
        {4'd9, 1'b0, 1'b1, 5'd0,  5'd31, 32'h0,        32'h12345678, 32'hFFFFFFFF, 1'b1, 1'b0}, // R9
        {4'd9, 1'b0, 1'b1, 5'd4,  5'd4,  32'h0,        32'h0,        32'h00000010, 1'b1, 1'b0}, // R9
        {4'd2, 1'b0, 1'b1, 5'd20, 5'd10, 32'h0,        32'hA5A5A5A5, 32'hA5A5A5A5, 1'b1, 1'b0}, // R2
        {4'd3, 1'b1, 1'b1, 5'd0,  5'd0,  32'h0000010B, 32'h0,        32'h00000F00, 1'b1, 1'b0}, // R3
        {4'd2, 1'b1, 1'b1, 5'd0,  5'd31, 32'h000003E0, 32'h0F0F0F0F, 32'h0F0F0F0F, 1'b1, 1'b0}, // R2 reg form
        {4'd4, 1'b1, 1'b1, 5'd0,  5'd0,  32'h00000400, 32'h0,        32'h00000001, 1'b0, 1'b1}, // R4
        {4'd5, 1'b1, 1'b0, 5'd0,  5'd0,  32'hFFFFF000, 32'h00000055, 32'h00000055, 1'b0, 1'b0}, // R5
        {4'd5, 1'b0, 1'b0, 5'd0,  5'd31, 32'h0,        32'hDEADBEEF, 32'hDEADBEEF, 1'b0, 1'b0}, // R5
        {4'd8, 1'b0, 1'b1, 5'd31, 5'd31, 32'hFFFFFFFF, 32'h0,        32'h80000000, 1'b1, 1'b0}  // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic ur, input logic pr, input logic [4:0] lo,
                         input logic [4:0] hi, input logic [31:0] bd, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; use_reg = ur; pred = pr;
        imm_lo = lo; imm_hi = hi; src_bounds = bd; src_data = d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R7: reset state
        check("R7 out_valid in reset", {31'b0, out_valid}, 32'h0);
        check("R7 wr_en in reset", {31'b0, wr_en}, 32'h0);
        check("R7 bad_bounds in reset", {31'b0, bad_bounds}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][109], VEC[i][108], VEC[i][107:103], VEC[i][102:98],
                  VEC[i][97:66], VEC[i][65:34]);
            check($sformatf("R%0d vec%0d out_valid", VEC[i][113:110], i), {31'b0, out_valid}, 32'h1);
            check($sformatf("R%0d vec%0d result", VEC[i][113:110], i), result, VEC[i][33:2]);
            check($sformatf("R%0d vec%0d wr_en", VEC[i][113:110], i), {31'b0, wr_en}, {31'b0, VEC[i][1]});
            check($sformatf("R%0d vec%0d bad_bounds", VEC[i][113:110], i), {31'b0, bad_bounds}, {31'b0, VEC[i][0]});
        end

        // R6: no issue gives an empty slot one clock later
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #2;
        check("R6 idle out_valid", {31'b0, out_valid}, 32'h0);
        check("R6 idle wr_en", {31'b0, wr_en}, 32'h0);

        // R8: malformed bounds in immediate form leave result and flag alone
        issue(1'b0, 1'b1, 5'd0, 5'd3, 32'hFFFFFC00, 32'h00000100);
        check("R8 imm ignores bounds result", result, 32'h0000010F);
        check("R8 imm ignores bounds flag", {31'b0, bad_bounds}, 32'h0);

        // R7: reset asserted together with an issue wins
        @(negedge clk);
        in_valid = 1'b1; pred = 1'b1; use_reg = 1'b0; rst = 1'b1;
        @(posedge clk);
        #2;
        check("R7 reset over issue out_valid", {31'b0, out_valid}, 32'h0);
        check("R7 reset over issue wr_en", {31'b0, wr_en}, 32'h0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        @(posedge clk);
        #2;
        check("R6 after reset idle", {31'b0, out_valid}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule